// File: doc/BRIEF.md
# Audio Sample Fetch Engine

This block pulls audio words out of system memory and hands them to a local sample FIFO. Software programs a byte-wide register bank with a first and a last byte address, a FIFO fill threshold and a burst setting, then fires a start strobe. The engine walks the range in incrementing bursts on a simple request/grant read port. Each accepted 32-bit beat becomes one FIFO word, presented on a sample output. A consumer drains words with a pop strobe. The engine keeps its own count of the FIFO fill level and never requests more than the FIFO can take.

A six-bit event register records errors, underruns, the end of the range and FIFO full and empty crossings. Software clears events by writing ones. A mute layer selects which events reach the interrupt line. A separate mask bit suppresses the end-of-range event at its source. A channel-slot byte is held for the audio formatter downstream.

Top module: `audio_fetch_dma`

## Requirements
- R1: After reset the event register (offset 0x0D) reads 0, the mute register (0x0E) reads 0x3F, the mask register (0x0C) reads 0xFF, and busReq and irq are low.
- R2: Config register 0x00 has burst enable in bit 0 and a length select in bits 2:1 (0 = 4 beats, 1 = 8, 2 = 16). With burst enable clear, every request is one beat.
- R3: A write of 1 to bit 0 of 0x01 starts a walk. The walk goes from the first address (bytes 0x04..0x07, least significant byte at 0x04) to the last address (bytes 0x08..0x0B, same order) in 4-byte beats. The last address is inclusive, so last = first + N - 1 moves N bytes. A request stays up with a stable address and length until it is granted.
- R4: When fewer beats remain than the selected burst length, the rest of the range is fetched as single-beat requests.
- R5: A request is made only when the fill level is below the threshold (0x03) and the level plus the request length does not exceed the FIFO depth.
- R6: Event bit 2 (done) is set exactly one cycle after the edge that accepts the last beat of the range, and the engine is then idle.
- R7: With bit 7 of the mask register set, the done event is not recorded.
- R8: A write of 1 to bit 0 of 0x02 aborts a walk. busReq is low from the next cycle, and no done event follows.
- R9: A read error response sets event bit 5 and halts the engine with no further requests.
- R10: Writing 1 to an event bit clears it, and writing 0 leaves it alone. irq is high exactly when some event bit is set whose mute bit is 0.
- R11: Event bit 1 is set when the level reaches the FIFO depth. Bit 0 is set when a pop empties the FIFO. Bit 4 is set by a pop at level 0 while a walk is active.
- R12: Config bit 7 clears the fill level and always reads back 0. The other config bits are stored from the same write.
- R13: busLock is high during a request exactly when config bit 3 is set.
- R14: The slot register 0x0F drives slotEnable directly (for example 0x03 for two channels, 0x3F for six, 0xFF for eight).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 6 | Register offset |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data for regAddr |
| busReq | output | 1 | Burst read request |
| busAddr | output | 32 | Burst start byte address |
| busBeats | output | 5 | Beats in the request (1, 4, 8 or 16) |
| busLock | output | 1 | Locked-transfer indication |
| busGnt | input | 1 | Request accepted |
| rdValid | input | 1 | Read beat valid |
| rdData | input | 32 | Read beat data |
| rdErr | input | 1 | Error response on this beat |
| sampleValid | output | 1 | Beat written into the sample FIFO |
| sampleData | output | 32 | FIFO write word |
| popReq | input | 1 | Consumer removes one FIFO word |
| slotEnable | output | 8 | Active audio slot mask |
| irq | output | 1 | Interrupt request |

## Verification
Register writes take effect at the edge that samples them. Start and stop act on that same edge, so busReq changes in the cycle that follows the write. The done bit is checked twice: it must still be clear in the cycle right after the final beat edge, and it must be set one cycle later. Event and irq results from pops are read on the falling edge after the popping cycle has been clocked. Each stall check waits several idle cycles before reading the bus counters, so that a late request cannot hide.

// File: rtl/audio_fetch_pkg.sv
`timescale 1ns/1ps
package audio_fetch_pkg;
  localparam int REG_AW = 6;

  localparam logic [REG_AW-1:0] OFS_CFG    = 6'h00;
  localparam logic [REG_AW-1:0] OFS_GO     = 6'h01;
  localparam logic [REG_AW-1:0] OFS_HALT   = 6'h02;
  localparam logic [REG_AW-1:0] OFS_THRESH = 6'h03;
  localparam logic [REG_AW-1:0] OFS_SRC    = 6'h04;
  localparam logic [REG_AW-1:0] OFS_LAST   = 6'h08;
  localparam logic [REG_AW-1:0] OFS_MASK   = 6'h0C;
  localparam logic [REG_AW-1:0] OFS_EVENT  = 6'h0D;
  localparam logic [REG_AW-1:0] OFS_MUTE   = 6'h0E;
  localparam logic [REG_AW-1:0] OFS_SLOTS  = 6'h0F;

  localparam int EV_EMPTY = 0;
  localparam int EV_FULL  = 1;
  localparam int EV_DONE  = 2;
  localparam int EV_RETRY = 3;
  localparam int EV_LOST  = 4;
  localparam int EV_ERROR = 5;

  typedef struct packed {
    logic running;
    logic loadStart;
    logic takeBeat;
    logic fifoClear;
  } fetchStrobe_t;

  typedef enum logic [2:0] {ST_IDLE, ST_ARB, ST_REQ, ST_DATA, ST_FIN} fetchState_t;
endpackage

// File: rtl/audio_fetch_regs.sv
`timescale 1ns/1ps
module audio_fetch_regs
  import audio_fetch_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [REG_AW-1:0] addr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  output logic              burstEn,
  output logic [1:0]        burstSel,
  output logic              lockEn,
  output logic              fifoRst,
  output logic              goPulse,
  output logic              haltPulse,
  output logic [7:0]        thresh,
  output logic [AW-1:0]     srcAddr,
  output logic [AW-1:0]     lastAddr,
  output logic [7:0]        slots,
  input  logic [5:0]        evSet,
  output logic [5:0]        status,
  output logic              irq
);
  localparam int NB = AW / 8;

  logic [3:0] cfgReg;
  logic [7:0] maskReg;
  logic [5:0] muteReg;
  logic [7:0] srcB [NB];
  logic [7:0] lastB [NB];
  logic [5:0] evGated;
  logic [5:0] w1c;

  // Per-byte writes of the two address registers; every other register is
  // written in the single always_ff below.
  for (genvar i = 0; i < NB; i++) begin : g_bytes
    assign srcAddr[8*i +: 8]  = srcB[i];
    assign lastAddr[8*i +: 8] = lastB[i];
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        srcB[i]  <= '0;
        lastB[i] <= '0;
      end else if (wrEn) begin
        if (addr == OFS_SRC + REG_AW'(i))  srcB[i]  <= wrData;
        if (addr == OFS_LAST + REG_AW'(i)) lastB[i] <= wrData;
      end
    end
  end

  assign goPulse   = wrEn && (addr == OFS_GO) && wrData[0];
  assign haltPulse = wrEn && (addr == OFS_HALT) && wrData[0];
  assign fifoRst   = wrEn && (addr == OFS_CFG) && wrData[7];
  assign burstEn   = cfgReg[0];
  assign burstSel  = cfgReg[2:1];
  assign lockEn    = cfgReg[3];

  always_comb begin
    evGated = evSet;
    evGated[EV_DONE] = evSet[EV_DONE] && !maskReg[7];
    w1c = (wrEn && addr == OFS_EVENT) ? wrData[5:0] : 6'd0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg  <= '0;
      thresh  <= 8'h80;
      maskReg <= 8'hFF;
      muteReg <= 6'h3F;
      slots   <= '0;
      status  <= '0;
    end else begin
      status <= (status & ~w1c) | evGated;
      if (wrEn) begin
        case (addr)
          OFS_CFG:    cfgReg  <= wrData[3:0];
          OFS_THRESH: thresh  <= wrData;
          OFS_MASK:   maskReg <= wrData;
          OFS_MUTE:   muteReg <= wrData[5:0];
          OFS_SLOTS:  slots   <= wrData;
          default: ;
        endcase
      end
    end
  end

  assign irq = |(status & ~muteReg);

  always_comb begin
    rdData = '0;
    case (addr)
      OFS_CFG:    rdData = {4'd0, cfgReg};
      OFS_THRESH: rdData = thresh;
      OFS_MASK:   rdData = maskReg;
      OFS_EVENT:  rdData = {2'd0, status};
      OFS_MUTE:   rdData = {2'd0, muteReg};
      OFS_SLOTS:  rdData = slots;
      default: ;
    endcase
    for (int i = 0; i < NB; i++) begin
      if (addr == OFS_SRC + REG_AW'(i))  rdData = srcB[i];
      if (addr == OFS_LAST + REG_AW'(i)) rdData = lastB[i];
    end
  end
endmodule

// File: rtl/audio_fetch_ctrl.sv
`timescale 1ns/1ps
module audio_fetch_ctrl
  import audio_fetch_pkg::*;
#(
  parameter int FIFO_WORDS = 256,
  parameter int LVL_W      = 9,
  parameter int RB_W       = 31
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             goPulse,
  input  logic             haltPulse,
  input  logic             fifoRst,
  input  logic             burstEn,
  input  logic [1:0]       burstSel,
  input  logic [7:0]       thresh,
  input  logic [LVL_W-1:0] level,
  input  logic [RB_W-1:0]  remBeats,
  input  logic             busGnt,
  input  logic             rdValid,
  input  logic             rdErr,
  output logic             busReq,
  output logic [4:0]       busBeats,
  output fetchStrobe_t     strobe,
  output logic             evDone,
  output logic             evError
);
  fetchState_t state, stateNext;
  logic [4:0] lenReg, cntReg, want, pick;
  logic roomOk, beatOk;

  always_comb begin
    if (!burstEn) want = 5'd1;
    else begin
      case (burstSel)
        2'd0:    want = 5'd4;
        2'd1:    want = 5'd8;
        default: want = 5'd16;
      endcase
    end
    pick   = (remBeats < RB_W'(want)) ? 5'd1 : want;
    roomOk = (int'(level) < int'(thresh)) && (int'(level) + int'(pick) <= FIFO_WORDS);
    beatOk = (state == ST_DATA) && rdValid && !rdErr && !haltPulse;
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (goPulse) stateNext = ST_ARB;
      ST_ARB: begin
        if (remBeats == '0) stateNext = ST_FIN;
        else if (roomOk)    stateNext = ST_REQ;
      end
      ST_REQ: if (busGnt) stateNext = ST_DATA;
      ST_DATA: begin
        if (rdValid) begin
          if (rdErr)                       stateNext = ST_IDLE;
          else if (remBeats == RB_W'(1))   stateNext = ST_FIN;
          else if (cntReg == 5'd1)         stateNext = ST_ARB;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
    if (haltPulse) stateNext = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      lenReg <= 5'd1;
      cntReg <= '0;
    end else begin
      state <= stateNext;
      if (state == ST_ARB) lenReg <= pick;
      if (state == ST_REQ && busGnt) cntReg <= lenReg;
      else if (beatOk)               cntReg <= cntReg - 5'd1;
    end
  end

  assign busReq           = (state == ST_REQ);
  assign busBeats         = lenReg;
  assign strobe.running   = (state != ST_IDLE);
  assign strobe.loadStart = (state == ST_IDLE) && goPulse && !haltPulse;
  assign strobe.takeBeat  = beatOk;
  assign strobe.fifoClear = fifoRst;
  assign evDone           = (state == ST_FIN);
  assign evError          = (state == ST_DATA) && rdValid && rdErr && !haltPulse;
endmodule

// File: rtl/audio_fetch_dpath.sv
`timescale 1ns/1ps
module audio_fetch_dpath
  import audio_fetch_pkg::*;
#(
  parameter int AW         = 32,
  parameter int FIFO_WORDS = 256,
  parameter int LVL_W      = 9,
  parameter int RB_W       = 31
) (
  input  logic             clk,
  input  logic             rstN,
  input  fetchStrobe_t     strobe,
  input  logic [AW-1:0]    srcAddr,
  input  logic [AW-1:0]    lastAddr,
  input  logic             popReq,
  output logic [AW-1:0]    curAddr,
  output logic [RB_W-1:0]  remBeats,
  output logic [LVL_W-1:0] level,
  output logic             evFull,
  output logic             evEmpty,
  output logic             evLost
);
  logic [AW+1:0] span;
  logic [LVL_W-1:0] levelNext;
  logic pop, push;

  always_comb begin
    span     = {2'b00, lastAddr} + (AW+2)'(1) - {2'b00, curAddr};
    remBeats = span[AW+1] ? '0 : span[AW:2];
    push     = strobe.takeBeat;
    pop      = popReq && (level != '0);
    if (strobe.fifoClear) levelNext = '0;
    else                  levelNext = level + LVL_W'(push) - LVL_W'(pop);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr <= '0;
      level   <= '0;
    end else begin
      level <= levelNext;
      if (strobe.loadStart)     curAddr <= srcAddr;
      else if (strobe.takeBeat) curAddr <= curAddr + AW'(4);
    end
  end

  assign evFull  = !strobe.fifoClear && (levelNext == LVL_W'(FIFO_WORDS)) && (level != LVL_W'(FIFO_WORDS));
  assign evEmpty = !strobe.fifoClear && pop && !push && (level == LVL_W'(1));
  assign evLost  = popReq && (level == '0) && strobe.running;
endmodule

// File: rtl/audio_fetch_dma.sv
`timescale 1ns/1ps
module audio_fetch_dma
  import audio_fetch_pkg::*;
#(
  parameter int AW         = 32,
  parameter int FIFO_WORDS = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  output logic              busReq,
  output logic [AW-1:0]     busAddr,
  output logic [4:0]        busBeats,
  output logic              busLock,
  input  logic              busGnt,
  input  logic              rdValid,
  input  logic [31:0]       rdData,
  input  logic              rdErr,
  output logic              sampleValid,
  output logic [31:0]       sampleData,
  input  logic              popReq,
  output logic [7:0]        slotEnable,
  output logic              irq
);
  localparam int LVL_W = $clog2(FIFO_WORDS + 1);
  localparam int RB_W  = AW - 1;

  logic burstEn, lockEn, fifoRst, goPulse, haltPulse;
  logic [1:0] burstSel;
  logic [7:0] thresh;
  logic [AW-1:0] srcAddr, lastAddr;
  logic [5:0] status, evSet;
  logic [LVL_W-1:0] level;
  logic [RB_W-1:0] remBeats;
  logic evDone, evError, evFull, evEmpty, evLost;
  fetchStrobe_t strobe;

  audio_fetch_regs #(.AW(AW)) i_regs (
    .clk, .rstN, .wrEn(regWrEn), .addr(regAddr), .wrData(regWrData), .rdData(regRdData),
    .burstEn, .burstSel, .lockEn, .fifoRst, .goPulse, .haltPulse, .thresh,
    .srcAddr, .lastAddr, .slots(slotEnable), .evSet, .status, .irq
  );

  audio_fetch_ctrl #(.FIFO_WORDS(FIFO_WORDS), .LVL_W(LVL_W), .RB_W(RB_W)) i_ctrl (
    .clk, .rstN, .goPulse, .haltPulse, .fifoRst, .burstEn, .burstSel, .thresh, .level,
    .remBeats, .busGnt, .rdValid, .rdErr, .busReq, .busBeats, .strobe, .evDone, .evError
  );

  audio_fetch_dpath #(.AW(AW), .FIFO_WORDS(FIFO_WORDS), .LVL_W(LVL_W), .RB_W(RB_W)) i_dpath (
    .clk, .rstN, .strobe, .srcAddr, .lastAddr, .popReq, .curAddr(busAddr), .remBeats,
    .level, .evFull, .evEmpty, .evLost
  );

  assign evSet       = {evError, evLost, 1'b0, evDone, evFull, evEmpty};
  assign busLock     = lockEn && busReq;
  assign sampleValid = strobe.takeBeat;
  assign sampleData  = rdData;
endmodule

// File: rtl/audio_fetch_chk.sv
`timescale 1ns/1ps
module audio_fetch_chk #(
  parameter int AW         = 32,
  parameter int FIFO_WORDS = 256,
  parameter int LVL_W      = 9
) (
  input logic             clk,
  input logic             rstN,
  input logic             busReq,
  input logic             busGnt,
  input logic             haltPulse,
  input logic [AW-1:0]    busAddr,
  input logic [4:0]       busBeats,
  input logic [AW-1:0]    lastAddr,
  input logic [LVL_W-1:0] level,
  input logic [5:0]       status,
  input logic             sampleValid
);
  a_r2_len_legal: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> (busBeats == 5'd1 || busBeats == 5'd4 || busBeats == 5'd8 || busBeats == 5'd16));

  a_r4_no_past_end: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> ((AW+1)'(busAddr) + (AW+1)'({busBeats, 2'b00}) - (AW+1)'(1)) <= (AW+1)'(lastAddr));

  a_r3_req_held: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busGnt && !haltPulse) |=> (busReq && $stable(busAddr) && $stable(busBeats)));

  a_r5_room: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> (int'(level) + int'(busBeats) <= FIFO_WORDS));

  a_r6_done_after_beat: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status[2]) |-> $past(sampleValid, 2));

  a_r8_halt_drops_req: assert property (@(posedge clk) disable iff (!rstN)
    haltPulse |=> !busReq);

  a_r9_error_stops: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status[5]) |-> !busReq);
endmodule

bind audio_fetch_dma audio_fetch_chk #(.AW(AW), .FIFO_WORDS(FIFO_WORDS), .LVL_W(LVL_W)) i_chk (
  .clk(clk), .rstN(rstN), .busReq(busReq), .busGnt(busGnt), .haltPulse(haltPulse),
  .busAddr(busAddr), .busBeats(busBeats), .lastAddr(lastAddr), .level(level),
  .status(status), .sampleValid(sampleValid)
);

// File: tb/test_audio_fetch_dma.sv
`timescale 1ns/1ps
module test_audio_fetch_dma;
  localparam int DEPTH = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [5:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic busReq, busLock, sampleValid, irq;
  logic [31:0] busAddr, sampleData;
  logic [4:0] busBeats;
  logic busGnt = 1'b0, rdValid = 1'b0, rdErr = 1'b0, popReq = 1'b0;
  logic [31:0] rdData = '0;
  logic [7:0] slotEnable;

  audio_fetch_dma #(.AW(32), .FIFO_WORDS(DEPTH)) i_audio_fetch_dma (
    .clk, .rstN, .regWrEn, .regAddr, .regWrData, .regRdData, .busReq, .busAddr,
    .busBeats, .busLock, .busGnt, .rdValid, .rdData, .rdErr, .sampleValid,
    .sampleData, .popReq, .slotEnable, .irq
  );

  always #2.5 clk = ~clk;

  int nChecks = 0;
  int nBad = 0;

  // bus slave model state
  logic holdGrant = 1'b0;
  logic [31:0] errAddr = 32'hFFFF_FFF0;
  int slvBeats = 0;
  logic [31:0] slvAddr = '0;
  logic [31:0] expAddr = '0;
  int beatCount = 0;
  int burstCount = 0;
  int firstLen = 0;
  int addrBad = 0;
  logic lockSeen = 1'b0;

  always @(negedge clk) begin
    busGnt = 1'b0;
    rdValid = 1'b0;
    rdErr = 1'b0;
    if (!rstN) slvBeats = 0;
    else if (slvBeats > 0) begin
      rdValid = 1'b1;
      rdData = slvAddr;
      rdErr = (slvAddr == errAddr);
      if (slvAddr != expAddr) addrBad++;
      expAddr = expAddr + 32'd4;
      slvAddr = slvAddr + 32'd4;
      slvBeats--;
      beatCount++;
    end else if (busReq && !holdGrant) begin
      busGnt = 1'b1;
      slvBeats = int'(busBeats);
      slvAddr = busAddr;
      burstCount++;
      if (burstCount == 1) firstLen = int'(busBeats);
      if (busLock) lockSeen = 1'b1;
    end
  end

  typedef struct packed {
    logic [7:0]  cfg;
    logic [31:0] src;
    logic [31:0] last;
    logic [7:0]  beats;
    logic [7:0]  bursts;
    logic [7:0]  firstLen;
    logic        lock;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{8'h09, 32'h0000_1000, 32'h0000_103F, 8'd16, 8'd4, 8'd4,  1'b1},
    '{8'h03, 32'h0000_2000, 32'h0000_2027, 8'd10, 8'd3, 8'd8,  1'b0},
    '{8'h05, 32'h0000_3000, 32'h0000_303F, 8'd16, 8'd1, 8'd16, 1'b0},
    '{8'h00, 32'h0000_4000, 32'h0000_400F, 8'd4,  8'd4, 8'd1,  1'b0},
    '{8'h05, 32'h0000_5000, 32'h0000_504F, 8'd20, 8'd5, 8'd16, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] v);
    @(negedge clk);
    regAddr = a;
    #1 v = regRdData;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pop(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); popReq = 1'b1;
    end
    @(negedge clk); popReq = 1'b0;
  endtask

  task automatic prep(input logic [7:0] cfg, input logic [31:0] src, input logic [31:0] last);
    wr(6'h00, cfg | 8'h80);
    wr(6'h0D, 8'h3F);
    for (int i = 0; i < 4; i++) begin
      wr(6'h04 + 6'(i), src[8*i +: 8]);
      wr(6'h08 + 6'(i), last[8*i +: 8]);
    end
    beatCount = 0; burstCount = 0; firstLen = 0; addrBad = 0; lockSeen = 1'b0;
    expAddr = src;
  endtask

  initial begin
    #(200000 * 5);
    nBad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    idle(4);
    rstN = 1'b1;
    // R1 reset values
    rd(6'h0D, v); chk("R1 event reset", v, 8'h00);
    rd(6'h0E, v); chk("R1 mute reset", v, 8'h3F);
    rd(6'h0C, v); chk("R1 mask reset", v, 8'hFF);
    chk("R1 busReq reset", busReq, 1'b0);
    chk("R1 irq reset", irq, 1'b0);

    // R14 slot byte
    wr(6'h0F, 8'h0B);
    chk("R14 slotEnable", slotEnable, 8'h0B);
    rd(6'h0F, v); chk("R14 slot readback", v, 8'h0B);

    wr(6'h03, 8'd32);
    wr(6'h0C, 8'h7F);
    wr(6'h0E, 8'h3B);

    // Vector table: R2 R3 R4 R6 R10 R13
    foreach (VECS[k]) begin
      prep(VECS[k].cfg, VECS[k].src, VECS[k].last);
      wr(6'h01, 8'h01);
      regAddr = 6'h0D;
      wait (beatCount == int'(VECS[k].beats));
      @(posedge clk);
      @(negedge clk); #1 chk("R6 done not early", regRdData[2], 1'b0);
      @(negedge clk); #1 chk("R6 done one cycle after last beat", regRdData[2], 1'b1);
      idle(4);
      chk("R6 idle after done", busReq, 1'b0);
      chk("R3 beat count", beatCount, VECS[k].beats);
      chk("R3 address walk", addrBad, 0);
      chk("R4 burst count", burstCount, VECS[k].bursts);
      chk("R2 first burst length", firstLen, VECS[k].firstLen);
      chk("R13 lock seen", lockSeen, VECS[k].lock);
      rd(6'h0D, v); chk("R6 event only done", v, 8'h04);
      chk("R10 irq on unmuted done", irq, 1'b1);
    end

    // R7 mask suppresses done
    wr(6'h0C, 8'hFF);
    prep(8'h01, 32'h6000, 32'h600F);
    wr(6'h01, 8'h01);
    wait (beatCount == 4);
    idle(4);
    rd(6'h0D, v); chk("R7 masked done", v, 8'h00);
    chk("R7 idle", busReq, 1'b0);

    // R10 mute and write-one-to-clear
    wr(6'h0C, 8'h7F);
    prep(8'h01, 32'h6000, 32'h600F);
    wr(6'h0E, 8'h3F);
    wr(6'h01, 8'h01);
    wait (beatCount == 4);
    idle(4);
    chk("R10 irq muted", irq, 1'b0);
    wr(6'h0E, 8'h3B);
    chk("R10 irq unmuted", irq, 1'b1);
    wr(6'h0D, 8'h01);
    rd(6'h0D, v); chk("R10 clear other bit keeps done", v, 8'h04);
    wr(6'h0D, 8'h04);
    rd(6'h0D, v); chk("R10 done cleared", v, 8'h00);
    chk("R10 irq dropped", irq, 1'b0);

    // R8 halt
    holdGrant = 1'b1;
    prep(8'h01, 32'h7000, 32'h70FF);
    wr(6'h01, 8'h01);
    idle(3);
    chk("R8 request pending", busReq, 1'b1);
    wr(6'h02, 8'h01);
    chk("R8 request dropped", busReq, 1'b0);
    holdGrant = 1'b0;
    idle(8);
    chk("R8 stays idle", busReq, 1'b0);
    rd(6'h0D, v); chk("R8 no done", v, 8'h00);

    // R9 error response
    errAddr = 32'h8008;
    prep(8'h01, 32'h8000, 32'h803F);
    wr(6'h01, 8'h01);
    wait (beatCount == 4);
    idle(8);
    rd(6'h0D, v); chk("R9 error event", v, 8'h20);
    chk("R9 no further request", burstCount, 1);
    chk("R9 halted", busReq, 1'b0);
    errAddr = 32'hFFFF_FFF0;

    // R5 threshold stall
    wr(6'h03, 8'd4);
    prep(8'h01, 32'h9000, 32'h90FF);
    wr(6'h01, 8'h01);
    wait (beatCount == 4);
    idle(10);
    chk("R5 stall at threshold", burstCount, 1);
    pop(1);
    idle(6);
    chk("R5 resume below threshold", burstCount, 2);
    wr(6'h02, 8'h01);
    idle(20);

    // R11 full, R5 room, empty, lost
    wr(6'h03, 8'd32);
    prep(8'h05, 32'hA000, 32'hA0FF);
    wr(6'h01, 8'h01);
    wait (beatCount == 32);
    idle(8);
    rd(6'h0D, v); chk("R11 full event", v & 8'h02, 8'h02);
    chk("R5 two bursts fill FIFO", burstCount, 2);
    pop(2);
    idle(8);
    chk("R5 no request without room", burstCount, 2);
    chk("R5 no request pending", busReq, 1'b0);
    wr(6'h02, 8'h01);
    wr(6'h0D, 8'h3F);
    pop(30);
    rd(6'h0D, v); chk("R11 empty event", v & 8'h11, 8'h01);
    pop(1);
    rd(6'h0D, v); chk("R11 no lost while idle", v & 8'h10, 8'h00);
    holdGrant = 1'b1;
    prep(8'h05, 32'hA000, 32'hA0FF);
    wr(6'h01, 8'h01);
    idle(3);
    pop(1);
    rd(6'h0D, v); chk("R11 lost on underrun", v & 8'h10, 8'h10);
    wr(6'h02, 8'h01);
    holdGrant = 1'b0;
    idle(4);

    // R12 soft FIFO reset
    prep(8'h05, 32'hB000, 32'hB0FF);
    wr(6'h01, 8'h01);
    wait (beatCount == 32);
    idle(6);
    chk("R12 full before clear", burstCount, 2);
    wr(6'h00, 8'h85);
    rd(6'h00, v); chk("R12 config readback", v, 8'h05);
    idle(6);
    chk("R12 level cleared allows fetch", burstCount, 3);
    wr(6'h02, 8'h01);
    idle(20);

    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end
endmodule